// File: doc/BRIEF.md
# DMA Channel Descriptor Sequencer

This block is the control engine of a single DMA channel. Software builds a linked list of descriptors in memory and pulses a start input with the address of the first one. The sequencer reads each descriptor one word at a time over a request/acknowledge fetch port. It decodes the control word and writes any programmed-I/O words to the attached peripheral, one handshake per word. It then moves the buffer through a request/grant memory arbiter in bursts, either memory-to-peripheral or peripheral-to-memory.

When the data phase ends, the sequencer can stall until the peripheral reports the command finished, or until the device reports ready. It then raises an optional completion pulse and either follows the link to the next descriptor or parks. A terminate input abandons the descriptor. A granted burst is always allowed to finish first. After that the channel goes back to idle, or it locks in a halted state when halt-on-terminate is set. The registered state is visible at all times on a 5-bit debug output. The arbiter and the byte-moving datapath sit outside this block and appear only as handshakes.

Descriptor layout, in 32-bit words at increasing byte addresses from the descriptor base:
- +0: link to the next descriptor.
- +4: control word.
- +8: buffer address.
- +12 onward: programmed-I/O words, one per count.

Control word fields:
- [1:0] transfer kind: 0 = none, 1 = peripheral-to-memory, 2 = memory-to-peripheral, 3 = none.
- [2] link-follow.
- [3] completion pulse enable.
- [4] wait for command end.
- [5] wait for device ready.
- [11:8] programmed-I/O word count.
- [31:16] byte count.

Top module: `dma_desc_seq`

## Requirements
- R1: Reset, and a synchronous `chan_rst` from any state, put the sequencer in idle (`dbg_state` = 0x00) on the next clock edge.
- R2: `dbg_state` shows the registered state with these codes: idle 0x00, word0 fetch 0x01, word2 fetch 0x02, word1 fetch 0x03, decode 0x04, PIO write 0x05, PIO word fetch 0x06, PIO check 0x07, read flush 0x08, read wait 0x09, write request 0x0C, read request 0x0D, link check 0x0E, descriptor done 0x0F, terminating 0x14, end wait 0x15, write wait 0x1C, halted 0x1D, parked 0x1E, ready wait 0x1F.
- R3: The link word, control word and buffer word are fetched in that order from base, base+4 and base+8. `fetch_req` and `fetch_addr` are held until `fetch_ack`, and the control fields follow the layout above.
- R4: For a PIO count N > 0, the word at base+12+4*i is fetched and then written with `pio_idx` = i, for i = 0..N-1. Each write is held until `pio_done`. A count of 0 skips this phase.
- R5: For a memory-to-peripheral transfer, `mem_req` with `mem_we` = 0 is held until `mem_gnt`, and the state then waits for `mem_done`. Bursts are min(remaining, BURST) bytes at successive addresses. After the last burst the state waits for `flush_done`.
- R6: A peripheral-to-memory transfer uses the same bursts with `mem_we` = 1 and has no flush step.
- R7: A transfer kind of none, or a byte count of 0, raises no `mem_req` and goes straight to descriptor done.
- R8: With the end-wait bit set, the sequencer stalls until `cmd_end`. With the ready-wait bit set, it then stalls until `dev_ready`.
- R9: At link check, link-follow = 1 fetches the next descriptor from the stored link. Link-follow = 0 parks the sequencer, and `start` is ignored while parked.
- R10: `term` in any active state enters terminating with `mem_req` low. The sequencer stays there while a granted burst is outstanding. It then goes to idle, or to halted when `halt_on_term` = 1. Only a reset leaves halted.
- R11: `done_pulse` is high for exactly the one cycle spent in link check, and only when the completion pulse enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_rst | input | 1 | Synchronous channel reset |
| halt_on_term | input | 1 | Lock in the halted state after a terminate |
| start | input | 1 | Begin a chain from idle |
| start_addr | input | AW | Address of the first descriptor |
| term | input | 1 | Terminate request |
| fetch_req | output | 1 | Descriptor word read request |
| fetch_addr | output | AW | Descriptor word address |
| fetch_ack | input | 1 | Read done, data valid |
| fetch_data | input | 32 | Descriptor word |
| pio_wr | output | 1 | Peripheral register write request |
| pio_idx | output | 4 | Index of the PIO word |
| pio_data | output | 32 | PIO word |
| pio_done | input | 1 | Peripheral write completed |
| mem_req | output | 1 | Burst request to the arbiter |
| mem_we | output | 1 | 1 = burst writes memory |
| mem_addr | output | AW | Burst start address |
| mem_len | output | 16 | Burst length in bytes |
| mem_gnt | input | 1 | Arbiter accepted the burst |
| mem_done | input | 1 | Granted burst finished |
| flush_done | input | 1 | Last read bytes passed to the peripheral |
| cmd_end | input | 1 | Peripheral finished the command |
| dev_ready | input | 1 | External device ready |
| done_pulse | output | 1 | Descriptor completion pulse |
| dbg_state | output | 5 | Current state code |

## Verification
The hardest case to reach from the ports is a terminate that arrives while a granted burst is still in flight. The sequencer must then hold in terminating until the late `mem_done`, and it must take the halted exit only when halt-on-terminate is set. The bench arms a one-cycle terminate pulse that fires when its reference model enters a chosen state: once during a read wait, to test the outstanding-burst hold, and once during a write request, with halting enabled. Randomised handshake delays keep each request held for several cycles, so the hold-until-acknowledge behaviour is exercised throughout.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [4:0] {
        S_IDLE     = 5'h00,
        S_CMD1     = 5'h01,
        S_CMD3     = 5'h02,
        S_CMD2     = 5'h03,
        S_DECODE   = 5'h04,
        S_PIO_WAIT = 5'h05,
        S_CMD4     = 5'h06,
        S_PIO_NEXT = 5'h07,
        S_RD_FLUSH = 5'h08,
        S_RD_WAIT  = 5'h09,
        S_WR_REQ   = 5'h0C,
        S_RD_REQ   = 5'h0D,
        S_CHAIN    = 5'h0E,
        S_XDONE    = 5'h0F,
        S_TERM     = 5'h14,
        S_WAIT_END = 5'h15,
        S_WR_WAIT  = 5'h1C,
        S_HALT     = 5'h1D,
        S_PARKED   = 5'h1E,
        S_WAIT_RDY = 5'h1F
    } dseq_state_e;

    localparam logic [1:0] XT_WRITE = 2'd1;
    localparam logic [1:0] XT_READ  = 2'd2;

    typedef struct packed {
        logic [15:0] nbytes;
        logic [3:0]  rsv_hi;
        logic [3:0]  pio_cnt;
        logic [1:0]  rsv_lo;
        logic        wait_rdy;
        logic        wait_end;
        logic        irq;
        logic        chain;
        logic [1:0]  xkind;
    } dseq_ctrl_t;

endpackage

// File: rtl/dseq_desc.sv
module dseq_desc
    import dseq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int BURST = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  dseq_state_e   state_q,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          fetch_ack,
    input  logic [31:0]   fetch_data,
    input  logic          pio_done,
    input  logic          mem_done,
    output logic [AW-1:0] fetch_addr,
    output dseq_ctrl_t    ctrl,
    output logic [3:0]    pio_sent,
    output logic [31:0]   pio_word,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_len,
    output logic          last_burst
);
    localparam int LW = 16;
    localparam logic [LW-1:0] BURST_L = LW'(BURST);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] link;
        dseq_ctrl_t    ctrl;
        logic [AW-1:0] cur;
        logic [LW-1:0] rem;
        logic [3:0]    sent;
        logic [31:0]   pword;
    } desc_regs_t;

    desc_regs_t r_q, r_d;
    logic [LW-1:0] blen;

    always_comb begin
        blen = (r_q.rem < BURST_L) ? r_q.rem : BURST_L;
        r_d  = r_q;
        case (state_q)
            S_IDLE:     if (start) r_d.base = start_addr;
            S_CMD1:     if (fetch_ack) r_d.link = AW'(fetch_data);
            S_CMD2:     if (fetch_ack) r_d.ctrl = dseq_ctrl_t'(fetch_data);
            S_CMD3:     if (fetch_ack) r_d.cur = AW'(fetch_data);
            S_DECODE: begin
                r_d.rem  = r_q.ctrl.nbytes;
                r_d.sent = '0;
            end
            S_CMD4:     if (fetch_ack) r_d.pword = fetch_data;
            S_PIO_WAIT: if (pio_done) r_d.sent = r_q.sent + 4'd1;
            S_RD_WAIT, S_WR_WAIT: begin
                if (mem_done) begin
                    r_d.cur = r_q.cur + AW'(blen);
                    r_d.rem = r_q.rem - blen;
                end
            end
            S_CHAIN:    if (r_q.ctrl.chain) r_d.base = r_q.link;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (state_q)
            S_CMD2:  fetch_addr = r_q.base + AW'(4);
            S_CMD3:  fetch_addr = r_q.base + AW'(8);
            S_CMD4:  fetch_addr = r_q.base + AW'(12) + AW'({r_q.sent, 2'b00});
            default: fetch_addr = r_q.base;
        endcase
    end

    assign ctrl       = r_q.ctrl;
    assign pio_sent   = r_q.sent;
    assign pio_word   = r_q.pword;
    assign mem_addr   = r_q.cur;
    assign mem_len    = blen;
    assign last_burst = (r_q.rem <= BURST_L);

    // R5: a burst request never carries an empty or oversized length
    a_r5_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {S_RD_REQ, S_WR_REQ}) |-> (mem_len != '0 && mem_len <= BURST_L));

endmodule

// File: rtl/dseq_fsm.sv
module dseq_fsm
    import dseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chan_rst,
    input  logic        halt_on_term,
    input  logic        start,
    input  logic        term,
    input  logic        fetch_ack,
    input  logic        pio_done,
    input  logic        mem_gnt,
    input  logic        mem_done,
    input  logic        flush_done,
    input  logic        cmd_end,
    input  logic        dev_ready,
    input  dseq_ctrl_t  ctrl,
    input  logic [3:0]  pio_sent,
    input  logic        last_burst,
    output dseq_state_e state_q,
    output logic        done_pulse
);
    typedef struct packed {
        dseq_state_e st;
        logic        busy;
        logic        done;
    } fsm_regs_t;

    fsm_regs_t f_q, f_d;
    dseq_state_e data_st;
    dseq_state_e post_st;
    logic        req_now;
    logic        active;

    always_comb begin
        if (ctrl.xkind == XT_READ && ctrl.nbytes != '0)       data_st = S_RD_REQ;
        else if (ctrl.xkind == XT_WRITE && ctrl.nbytes != '0) data_st = S_WR_REQ;
        else                                                  data_st = S_XDONE;
        post_st = ctrl.wait_rdy ? S_WAIT_RDY : S_CHAIN;
        req_now = f_q.st inside {S_RD_REQ, S_WR_REQ};
        active  = !(f_q.st inside {S_IDLE, S_TERM, S_HALT, S_PARKED});

        f_d      = f_q;
        f_d.busy = (f_q.busy && !mem_done) || (req_now && mem_gnt);
        case (f_q.st)
            S_IDLE:     if (start) f_d.st = S_CMD1;
            S_CMD1:     if (fetch_ack) f_d.st = S_CMD2;
            S_CMD2:     if (fetch_ack) f_d.st = S_CMD3;
            S_CMD3:     if (fetch_ack) f_d.st = S_DECODE;
            S_DECODE:   f_d.st = (ctrl.pio_cnt != '0) ? S_CMD4 : data_st;
            S_CMD4:     if (fetch_ack) f_d.st = S_PIO_WAIT;
            S_PIO_WAIT: if (pio_done) f_d.st = S_PIO_NEXT;
            S_PIO_NEXT: f_d.st = (pio_sent < ctrl.pio_cnt) ? S_CMD4 : data_st;
            S_RD_REQ:   if (mem_gnt) f_d.st = S_RD_WAIT;
            S_RD_WAIT:  if (mem_done) f_d.st = last_burst ? S_RD_FLUSH : S_RD_REQ;
            S_RD_FLUSH: if (flush_done) f_d.st = S_XDONE;
            S_WR_REQ:   if (mem_gnt) f_d.st = S_WR_WAIT;
            S_WR_WAIT:  if (mem_done) f_d.st = last_burst ? S_XDONE : S_WR_REQ;
            S_XDONE:    f_d.st = ctrl.wait_end ? S_WAIT_END : post_st;
            S_WAIT_END: if (cmd_end) f_d.st = post_st;
            S_WAIT_RDY: if (dev_ready) f_d.st = S_CHAIN;
            S_CHAIN:    f_d.st = ctrl.chain ? S_CMD1 : S_PARKED;
            S_TERM:     if (!f_q.busy) f_d.st = halt_on_term ? S_HALT : S_IDLE;
            default: ;
        endcase
        if (term && active) f_d.st = S_TERM;
        if (chan_rst) begin
            f_d.st   = S_IDLE;
            f_d.busy = 1'b0;
        end
        f_d.done = (f_d.st == S_CHAIN) && ctrl.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: S_IDLE, busy: 1'b0, done: 1'b0};
        else        f_q <= f_d;
    end

    assign state_q    = f_q.st;
    assign done_pulse = f_q.done;

    a_r1_chan_rst_idle: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (state_q == S_IDLE));

    a_r9_parked_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PARKED && !chan_rst) |=> (state_q == S_PARKED));

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT && !chan_rst) |=> (state_q == S_HALT));

    a_r10_term_holds_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TERM && f_q.busy && !chan_rst) |=> (state_q == S_TERM));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
    import dseq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int BURST = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_rst,
    input  logic          halt_on_term,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          term,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    input  logic          fetch_ack,
    input  logic [31:0]   fetch_data,
    output logic          pio_wr,
    output logic [3:0]    pio_idx,
    output logic [31:0]   pio_data,
    input  logic          pio_done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_len,
    input  logic          mem_gnt,
    input  logic          mem_done,
    input  logic          flush_done,
    input  logic          cmd_end,
    input  logic          dev_ready,
    output logic          done_pulse,
    output logic [4:0]    dbg_state
);
    dseq_state_e state_q;
    dseq_ctrl_t  ctrl;
    logic [3:0]  pio_sent;
    logic        last_burst;

    dseq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_rst     (chan_rst),
        .halt_on_term (halt_on_term),
        .start        (start),
        .term         (term),
        .fetch_ack    (fetch_ack),
        .pio_done     (pio_done),
        .mem_gnt      (mem_gnt),
        .mem_done     (mem_done),
        .flush_done   (flush_done),
        .cmd_end      (cmd_end),
        .dev_ready    (dev_ready),
        .ctrl         (ctrl),
        .pio_sent     (pio_sent),
        .last_burst   (last_burst),
        .state_q      (state_q),
        .done_pulse   (done_pulse)
    );

    dseq_desc #(.AW(AW), .BURST(BURST)) u_desc (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .start      (start),
        .start_addr (start_addr),
        .fetch_ack  (fetch_ack),
        .fetch_data (fetch_data),
        .pio_done   (pio_done),
        .mem_done   (mem_done),
        .fetch_addr (fetch_addr),
        .ctrl       (ctrl),
        .pio_sent   (pio_sent),
        .pio_word   (pio_data),
        .mem_addr   (mem_addr),
        .mem_len    (mem_len),
        .last_burst (last_burst)
    );

    assign fetch_req = state_q inside {S_CMD1, S_CMD2, S_CMD3, S_CMD4};
    assign pio_wr    = (state_q == S_PIO_WAIT);
    assign pio_idx   = pio_sent;
    assign mem_req   = state_q inside {S_RD_REQ, S_WR_REQ};
    assign mem_we    = (state_q == S_WR_REQ);
    assign dbg_state = state_q;

    a_r3_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack && !term && !chan_rst) |=> (fetch_req && $stable(fetch_addr)));

    a_r4_pio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pio_wr && !pio_done && !term && !chan_rst) |=>
            (pio_wr && $stable(pio_data) && $stable(pio_idx)));

    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !term && !chan_rst) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_we)));

    a_r10_quiet_in_term: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_state == 5'h14) |-> (!mem_req && !fetch_req && !pio_wr));

endmodule

// File: tb/dma_desc_seq_tb_top.sv
module dma_desc_seq_tb_top;
    localparam int AW = 32;
    localparam int BURST = 16;

    localparam int C_IDLE = 'h00, C_CMD1 = 'h01, C_CMD3 = 'h02, C_CMD2 = 'h03, C_DEC = 'h04;
    localparam int C_PWAIT = 'h05, C_CMD4 = 'h06, C_PNEXT = 'h07, C_FLUSH = 'h08, C_RWAIT = 'h09;
    localparam int C_WREQ = 'h0C, C_RREQ = 'h0D, C_CHAIN = 'h0E, C_XDONE = 'h0F, C_TERM = 'h14;
    localparam int C_WEND = 'h15, C_WWAIT = 'h1C, C_HALT = 'h1D, C_PARK = 'h1E, C_WRDY = 'h1F;

    logic clk = 0, rst_n = 0, chan_rst = 0, halt_on_term = 0, start = 0, term = 0;
    logic [AW-1:0] start_addr = '0;
    logic fetch_req, fetch_ack = 0, pio_wr, pio_done = 0, mem_req, mem_we;
    logic mem_gnt = 0, mem_done = 0, flush_done = 0, cmd_end = 0, dev_ready = 0, done_pulse;
    logic [AW-1:0] fetch_addr, mem_addr;
    logic [31:0] fetch_data = '0, pio_data;
    logic [3:0] pio_idx;
    logic [15:0] mem_len;
    logic [4:0] dbg_state;

    always #5 clk = ~clk;

    dma_desc_seq #(.AW(AW), .BURST(BURST)) dut_i (.*);

    logic [31:0] dmem [int];
    int nvec = 0, nbad = 0, cyc = 0;
    bit fin = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit armed = 0;
    int term_at = -1;
    int n_done = 0, n_req = 0, n_wend = 0, n_wrdy = 0;

    // reference model state
    int m_st = C_IDLE;
    bit m_busy = 0, m_done = 0;
    logic [31:0] m_base = 0, m_link = 0, m_ctl = 0, m_cur = 0, m_pw = 0;
    int m_rem = 0, m_sent = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return dmem.exists(a) ? dmem[a] : 32'h0;
    endfunction

    function automatic bit rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[1:0] != 2'b00;
    endfunction

    function automatic int blen_f();
        return (m_rem < BURST) ? m_rem : BURST;
    endfunction

    function automatic bit exp_freq();
        return m_st == C_CMD1 || m_st == C_CMD2 || m_st == C_CMD3 || m_st == C_CMD4;
    endfunction

    function automatic logic [31:0] exp_faddr();
        if (m_st == C_CMD2) return m_base + 4;
        if (m_st == C_CMD3) return m_base + 8;
        if (m_st == C_CMD4) return m_base + 12 + 4 * m_sent;
        return m_base;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = C_IDLE; m_busy = 0; m_done = 0; m_base = 0; m_link = 0;
            m_ctl = 0; m_cur = 0; m_rem = 0; m_sent = 0; m_pw = 0;
        end else begin
            int nx, ent, bl, kind, cnt;
            bit req, nbusy, act;
            nx = m_st;
            bl = blen_f();
            kind = int'(m_ctl[1:0]);
            cnt = int'(m_ctl[31:16]);
            ent = (kind == 2 && cnt != 0) ? C_RREQ : (kind == 1 && cnt != 0) ? C_WREQ : C_XDONE;
            req = (m_st == C_RREQ || m_st == C_WREQ);
            act = !(m_st == C_IDLE || m_st == C_TERM || m_st == C_HALT || m_st == C_PARK);
            case (m_st)
                C_IDLE:  if (start) nx = C_CMD1;
                C_CMD1:  if (fetch_ack) nx = C_CMD2;
                C_CMD2:  if (fetch_ack) nx = C_CMD3;
                C_CMD3:  if (fetch_ack) nx = C_DEC;
                C_DEC:   nx = (m_ctl[11:8] != 0) ? C_CMD4 : ent;
                C_CMD4:  if (fetch_ack) nx = C_PWAIT;
                C_PWAIT: if (pio_done) nx = C_PNEXT;
                C_PNEXT: nx = (m_sent < int'(m_ctl[11:8])) ? C_CMD4 : ent;
                C_RREQ:  if (mem_gnt) nx = C_RWAIT;
                C_RWAIT: if (mem_done) nx = (m_rem <= BURST) ? C_FLUSH : C_RREQ;
                C_FLUSH: if (flush_done) nx = C_XDONE;
                C_WREQ:  if (mem_gnt) nx = C_WWAIT;
                C_WWAIT: if (mem_done) nx = (m_rem <= BURST) ? C_XDONE : C_WREQ;
                C_XDONE: nx = m_ctl[4] ? C_WEND : (m_ctl[5] ? C_WRDY : C_CHAIN);
                C_WEND:  if (cmd_end) nx = m_ctl[5] ? C_WRDY : C_CHAIN;
                C_WRDY:  if (dev_ready) nx = C_CHAIN;
                C_CHAIN: nx = m_ctl[2] ? C_CMD1 : C_PARK;
                C_TERM:  if (!m_busy) nx = halt_on_term ? C_HALT : C_IDLE;
                default: ;
            endcase
            if (term && act) nx = C_TERM;
            nbusy = (m_busy && !mem_done) || (req && mem_gnt);
            if (chan_rst) begin nx = C_IDLE; nbusy = 0; end
            case (m_st)
                C_IDLE:  if (start) m_base = start_addr;
                C_CMD1:  if (fetch_ack) m_link = fetch_data;
                C_CMD2:  if (fetch_ack) m_ctl = fetch_data;
                C_CMD3:  if (fetch_ack) m_cur = fetch_data;
                C_DEC:   begin m_rem = cnt; m_sent = 0; end
                C_CMD4:  if (fetch_ack) m_pw = fetch_data;
                C_PWAIT: if (pio_done) m_sent++;
                C_RWAIT, C_WWAIT: if (mem_done) begin m_cur = m_cur + bl; m_rem = m_rem - bl; end
                C_CHAIN: if (m_ctl[2]) m_base = m_link;
                default: ;
            endcase
            m_done = (nx == C_CHAIN) && m_ctl[3];
            m_st = nx;
            m_busy = nbusy;
        end
    end

    // compare on every falling edge, then drive handshakes for the next edge
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            bit ereq;
            cyc++;
            ereq = (m_st == C_RREQ || m_st == C_WREQ);
            chk("R2 dbg_state", 32'(dbg_state), m_st);
            chk("R3 fetch_req", 32'(fetch_req), 32'(exp_freq()));
            if (exp_freq()) chk("R3 fetch_addr", fetch_addr, exp_faddr());
            chk("R4 pio_wr", 32'(pio_wr), 32'(m_st == C_PWAIT));
            if (m_st == C_PWAIT) begin
                chk("R4 pio_idx", 32'(pio_idx), m_sent);
                chk("R4 pio_data", pio_data, m_pw);
            end
            chk("R5 R6 R10 mem_req", 32'(mem_req), 32'(ereq));
            if (ereq) begin
                chk("R5 R6 mem_we", 32'(mem_we), 32'(m_st == C_WREQ));
                chk("R5 R6 mem_addr", mem_addr, m_cur);
                chk("R5 R6 mem_len", 32'(mem_len), blen_f());
            end
            chk("R11 done_pulse", 32'(done_pulse), 32'(m_done));
            n_done += int'(done_pulse);
            n_req  += int'(mem_req);
            n_wend += int'(dbg_state == 5'h15);
            n_wrdy += int'(dbg_state == 5'h1F);
            if (cyc > 60000) begin
                nbad++;
                $display("FAIL watchdog actual=%0d expected<=60000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
                fin = 1;
                $finish;
            end
        end
        fetch_ack  <= exp_freq() && rnd();
        fetch_data <= rd(exp_faddr());
        pio_done   <= (m_st == C_PWAIT) && rnd();
        mem_gnt    <= (m_st == C_RREQ || m_st == C_WREQ) && rnd();
        mem_done   <= m_busy && rnd();
        flush_done <= (m_st == C_FLUSH) && rnd();
        cmd_end    <= (m_st == C_WEND) && rnd();
        dev_ready  <= (m_st == C_WRDY) && rnd();
        if (armed && m_st == term_at) begin term <= 1'b1; armed = 0; end
        else term <= 1'b0;
    end

    task automatic kick(input logic [31:0] a);
        @(negedge clk); start = 1; start_addr = a;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_st(input int s);
        do @(negedge clk); while (m_st != s);
    endtask

    task automatic chreset();
        @(negedge clk); chan_rst = 1;
        @(negedge clk); chan_rst = 0;
        chk("R1 chan_rst to idle", 32'(dbg_state), C_IDLE);
    endtask

    task automatic clr();
        n_done = 0; n_req = 0; n_wend = 0; n_wrdy = 0;
    endtask

    initial begin
        // chain A (read 40 bytes, 2 PIO words, end-wait, irq) -> B (write 16, ready-wait)
        dmem[32'h100] = 32'h200; dmem[32'h104] = 32'h0028_021E; dmem[32'h108] = 32'h1000;
        dmem[32'h10C] = 32'hA5A5_0001; dmem[32'h110] = 32'hA5A5_0002;
        dmem[32'h200] = 32'h0;   dmem[32'h204] = 32'h0010_0021; dmem[32'h208] = 32'h2000;
        // C (no transfer, 1 PIO, irq, chain) -> C2 (read with zero count, irq)
        dmem[32'h300] = 32'h340; dmem[32'h304] = 32'h0000_010C; dmem[32'h308] = 32'h0;
        dmem[32'h30C] = 32'hCAFE_0000;
        dmem[32'h340] = 32'h0;   dmem[32'h344] = 32'h0000_000A; dmem[32'h348] = 32'h3000;
        // E: read 64 bytes ; F: write 48 bytes
        dmem[32'h400] = 32'h0;   dmem[32'h404] = 32'h0040_0002; dmem[32'h408] = 32'h4000;
        dmem[32'h500] = 32'h0;   dmem[32'h504] = 32'h0030_0001; dmem[32'h508] = 32'h5000;

        repeat (3) @(negedge clk);
        chk("R1 reset state", 32'(dbg_state), C_IDLE);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", 32'(dbg_state), C_IDLE);

        // R3 R4 R5 R6 R8 R9 R11: two linked descriptors
        clr();
        kick(32'h100);
        wait_st(C_PARK);
        chk("R11 one pulse for two descriptors", n_done, 1);
        chk("R8 end wait visited", 32'(n_wend > 0), 1);
        chk("R8 ready wait visited", 32'(n_wrdy > 0), 1);
        chk("R5 R6 bursts requested", 32'(n_req >= 4), 1);
        kick(32'h300);
        repeat (3) @(negedge clk);
        chk("R9 parked ignores start", 32'(dbg_state), C_PARK);
        chreset();

        // R7: no-transfer kind and zero byte count
        clr();
        kick(32'h300);
        wait_st(C_PARK);
        chk("R7 no memory request", n_req, 0);
        chk("R11 two pulses", n_done, 2);
        chreset();

        // R10: terminate while a read burst is outstanding, no halt
        clr();
        halt_on_term = 0; term_at = C_RWAIT; armed = 1;
        kick(32'h400);
        wait_st(C_TERM);
        wait_st(C_IDLE);
        repeat (2) @(negedge clk);
        chk("R10 back to idle", 32'(dbg_state), C_IDLE);

        // R10: terminate while requesting a write, halt enabled
        halt_on_term = 1; term_at = C_WREQ; armed = 1;
        kick(32'h500);
        wait_st(C_HALT);
        kick(32'h100);
        repeat (3) @(negedge clk);
        chk("R10 halt is sticky", 32'(dbg_state), C_HALT);
        chreset();
        halt_on_term = 0;
        repeat (2) @(negedge clk);

        fin = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule